// File: doc/BRIEF.md
# Tag-Matched Programmable Execution Slot

This block is an extra execution unit placed next to a register file. The decode stage issues a user-defined operation that carries an 11-bit function identifier and two source operands read from the register file. The slot keeps one configuration: the identifier of the function that is currently loaded and the operation that function performs. When the issued identifier matches the loaded one, the result goes back to the register file in the same cycle. When it does not match, the slot raises a fault, and trap software then loads the missing function.

The configurable array has no state of its own. A result depends only on the operands presented in that cycle and on the loaded operation, so a context switch only has to keep track of the tag. A small table of selectable operations stands in for the array. A tag-load port stands in for configuration loading: in a single write it replaces both the identifier and the operation.

Top module: `pfu_slot`

## Requirements
- R1: After reset no function is loaded. Every issued operation then raises `fault` and leaves `res_valid` low until the first load, whatever identifier it carries.
- R2: An issue whose identifier differs from the loaded tag raises `fault` in the same cycle. In that cycle `res_valid` is low and `result` is zero.
- R3: An issue whose identifier equals the loaded tag drives `res_valid` high and `fault` low in the same cycle. `result` is set by the loaded operation code: 0 a+b, 1 a-b, 2 a&b, 3 a|b, 4 a^b, 5 a shifted left by b, 6 a shifted right logically by b, 7 unsigned maximum of a and b. Sums and differences wrap modulo 2^32.
- R4: When `ld_en` is high at a rising edge, `ld_fid` and `ld_op` take effect from the next cycle onward. An issue in the same cycle as the load is still judged against the previous configuration.
- R5: While `issue_valid` is low, `fault` and `res_valid` are low and `result` is zero.
- R6: The unit keeps no state from one operation to the next. The same operands with the same loaded operation always give the same result, whatever was issued before.
- R7: Shift operations use only the low 5 bits of operand b as the shift amount.
- R8: The identifier comparison covers all 11 bits. A difference in any single bit, the top bit included, is a mismatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A user-defined operation is issued this cycle |
| issue_fid | input | 11 | Function identifier of the issued operation |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand |
| ld_en | input | 1 | Load a new configuration at this edge |
| ld_fid | input | 11 | Identifier to load |
| ld_op | input | 3 | Operation code to load |
| res_valid | output | 1 | Result is valid this cycle |
| result | output | 32 | Result returned to the register file |
| fault | output | 1 | Identifier mismatch, trap requested |

## Verification
Hit, fault and the result are combinational, so all three are due in the same cycle as the issue. Only a configuration load passes through a register, and it is due one edge after `ld_en` is sampled. The bench drives inputs on the falling edge and compares the outputs a nanosecond later, in the same cycle, against a behavioural model. The model takes in a load only at the following rising edge. This makes the cycle of a load and a same-cycle issue fall on the old configuration, as R4 requires.

// File: rtl/pfu_slot.sv
module pfu_slot #(
  parameter int FID_W  = 11,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [FID_W-1:0]  issue_fid,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic              ld_en,
  input  logic [FID_W-1:0]  ld_fid,
  input  logic [2:0]        ld_op,
  output logic              res_valid,
  output logic [DATA_W-1:0] result,
  output logic              fault
);
  localparam int SH_W = $clog2(DATA_W);

  logic [FID_W-1:0]  tag_q;
  logic              tag_ok_q;
  logic [2:0]        op_q;
  logic              hit;
  logic [DATA_W-1:0] op_out;
  logic [SH_W-1:0]   shamt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag_q    <= '1;
      tag_ok_q <= 1'b0;
      op_q     <= '0;
    end else if (ld_en) begin
      tag_q    <= ld_fid;
      tag_ok_q <= 1'b1;
      op_q     <= ld_op;
    end
  end

  assign hit   = issue_valid && tag_ok_q && (issue_fid == tag_q);
  assign shamt = src_b[SH_W-1:0];

  always_comb begin
    case (op_q)
      3'd0:    op_out = src_a + src_b;
      3'd1:    op_out = src_a - src_b;
      3'd2:    op_out = src_a & src_b;
      3'd3:    op_out = src_a | src_b;
      3'd4:    op_out = src_a ^ src_b;
      3'd5:    op_out = src_a << shamt;
      3'd6:    op_out = src_a >> shamt;
      default: op_out = (src_a > src_b) ? src_a : src_b;
    endcase
  end

  assign res_valid = hit;
  assign fault     = issue_valid && !hit;
  assign result    = hit ? op_out : '0;
endmodule

// File: rtl/pfu_slot_chk.sv
module pfu_slot_chk #(
  parameter int FID_W  = 11,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_valid,
  input logic [FID_W-1:0]  issue_fid,
  input logic              ld_en,
  input logic [FID_W-1:0]  ld_fid,
  input logic              res_valid,
  input logic [DATA_W-1:0] result,
  input logic              fault
);
  logic loaded_seen;
  always_ff @(posedge clk) begin
    if (!rst_n)     loaded_seen <= 1'b0;
    else if (ld_en) loaded_seen <= 1'b1;
  end

  a_r1_first_use_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (!loaded_seen && issue_valid) |-> (fault && !res_valid));

  a_r2_fault_no_result: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!res_valid && result == '0));

  a_r4_load_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_seen && $past(ld_en) && issue_valid && issue_fid == $past(ld_fid)) |-> res_valid);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (!fault && !res_valid && result == '0));
endmodule

bind pfu_slot pfu_slot_chk #(.FID_W(FID_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_fid(issue_fid),
  .ld_en(ld_en), .ld_fid(ld_fid), .res_valid(res_valid), .result(result),
  .fault(fault)
);

// File: tb/sim_pfu_slot.sv
`timescale 1ns/1ps
module sim_pfu_slot;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [10:0] issue_fid = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        ld_en = 1'b0;
  logic [10:0] ld_fid = '0;
  logic [2:0]  ld_op = '0;
  logic        res_valid, fault;
  logic [31:0] result;

  int checks = 0, errors = 0;
  bit done = 0;

  logic        m_ok = 0;
  logic [10:0] m_tag = '0;
  logic [2:0]  m_op = '0;

  always #2.5 clk = ~clk;

  pfu_slot u0 (.clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_fid(issue_fid),
    .src_a(src_a), .src_b(src_b), .ld_en(ld_en), .ld_fid(ld_fid), .ld_op(ld_op),
    .res_valid(res_valid), .result(result), .fault(fault));

  function automatic logic [31:0] ref_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b);
    int sh;
    sh = b % 32;
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return a << sh;
      6: return a >> sh;
      default: return (a > b) ? a : b;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit iv, input logic [10:0] fid,
                      input logic [31:0] a, input logic [31:0] b,
                      input bit ld, input logic [10:0] lf, input logic [2:0] lo);
    bit hit;
    @(negedge clk);
    issue_valid = iv; issue_fid = fid; src_a = a; src_b = b;
    ld_en = ld; ld_fid = lf; ld_op = lo;
    #1;
    hit = iv && m_ok && (fid == m_tag);
    chk({req, " res_valid"}, {31'b0, res_valid}, {31'b0, hit});
    chk({req, " fault"}, {31'b0, fault}, {31'b0, iv && !hit});
    chk({req, " result"}, result, hit ? ref_op(m_op, a, b) : 32'h0);
    @(posedge clk);
    if (ld) begin m_ok = 1; m_tag = lf; m_op = lo; end
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step("R5 reset idle", 0, 0, 0, 0, 0, 0, 0);
    step("R1 before load", 1, 11'h7FF, 5, 6, 0, 0, 0);
    step("R1 zero id", 1, 11'h000, 5, 6, 0, 0, 0);
    step("R4 load same cycle", 1, 11'h123, 1, 2, 1, 11'h123, 3'd0);
    step("R3 add", 1, 11'h123, 32'hFFFF_FFFF, 2, 0, 0, 0);
    step("R8 low bit", 1, 11'h122, 1, 2, 0, 0, 0);
    step("R8 top bit", 1, 11'h523, 1, 2, 0, 0, 0);
    step("R2 mismatch", 1, 11'h000, 9, 9, 0, 0, 0);
    step("R5 idle matching id", 0, 11'h123, 1, 2, 0, 0, 0);
    for (int op = 1; op < 8; op++) begin
      step("R4 reload", 0, 0, 0, 0, 1, 11'h040 + 11'(op), 3'(op));
      step("R3 op", 1, 11'h040 + 11'(op), 32'h8000_00F3, 32'h0000_0024, 0, 0, 0);
      step("R4 old tag now miss", 1, 11'h040 + 11'(op - 1), 3, 4, 0, 0, 0);
    end
    step("R4 shl", 0, 0, 0, 0, 1, 11'h3AA, 3'd5);
    step("R7 shl wrap", 1, 11'h3AA, 32'h1, 32'd33, 0, 0, 0);
    step("R7 shl high bits", 1, 11'h3AA, 32'h3, 32'hFFFF_FFE4, 0, 0, 0);
    step("R4 shr", 0, 0, 0, 0, 1, 11'h3AB, 3'd6);
    step("R7 shr", 1, 11'h3AB, 32'h8000_0000, 32'd63, 0, 0, 0);
    step("R4 sub", 1, 11'h3AB, 7, 1, 1, 11'h3AC, 3'd1);
    step("R6 sub a", 1, 11'h3AC, 10, 3, 0, 0, 0);
    step("R6 other", 1, 11'h3AC, 32'hDEAD, 32'hBEEF, 0, 0, 0);
    step("R6 sub again", 1, 11'h3AC, 10, 3, 0, 0, 0);
    step("R3 sub wrap", 1, 11'h3AC, 0, 1, 0, 0, 0);
    for (int i = 0; i < 400; i++) begin
      logic [10:0] f;
      f = ($urandom % 3 == 0) ? 11'($urandom) : m_tag;
      step("R6 random", 1'($urandom), f, $urandom, $urandom,
           ($urandom % 5 == 0), 11'($urandom % 4), 3'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule